// File: doc/BRIEF.md
# Fractional-Rate Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on an idle-high line, timed directly from the system clock. Every bit slot of a frame is a whole number of clocks: a base width N, plus one extra clock for each slot whose bit is set in a per-slot stretch mask. Because the same mask applies to every frame, the average bit rate can sit between two integer divisions of the clock. The bit-to-bit skew inside a frame is still the same from byte to byte.

Bytes enter over a valid/ready handshake into a single holding register. Three frame layouts are available: eight data bits with one stop bit, eight data bits with two stop bits, and eight data bits followed by a parity slot that is always high and then two stop bits. The last layout gives the longest high gap between bytes. A clear-to-send input lets the far end hold off the next frame. Software loads the divisor, mask and layout at run time while the line is quiet.

Top module: `frac_uart_tx`

## Requirements
- R1: After reset the line output is high, busy is low and ready is high.
- R2: The block holds exactly one waiting byte. Ready is low while that byte is held, and a byte offered while ready is low is not taken.
- R3: A frame is a low start slot, then the eight data bits least significant bit first, then high stop slots. Layout code 0 gives 10 slots in total.
- R4: With a zero mask, every slot lasts N clocks. A divisor written below 14 is raised to 14.
- R5: Mask bit i (bit 0 is the start slot, bits 1 to 8 are the data bits, bit 9 and up are the slots that follow) makes slot i last N+1 clocks.
- R6: Frames sent back to back have identical slot timing.
- R7: Layout code 1 gives 11 slots, the last two of them high.
- R8: Layout code 2 gives 12 slots: a parity slot that is always high, then two high stop slots. Code 3 behaves like code 0.
- R9: Mask bits at or above the active slot count have no effect.
- R10: Clear-to-send is looked at only between frames. While it is low no frame starts. Dropping it during a frame does not shorten that frame.
- R11: A configuration write has effect only while busy is low. A write made during a frame is discarded.
- R12: Busy is high from the clock in which the start slot begins until the end of the last stop slot. While busy is low the line is high.
- R13: If a byte is waiting and clear-to-send is high when a frame ends, the next start slot begins in the following clock. A byte accepted while the line is idle starts one clock after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | DIV_W | Base bit width N in clocks |
| cfg_mask | input | 12 | Per-slot stretch mask |
| cfg_fmt | input | 2 | Frame layout: 0 = one stop, 1 = two stops, 2 = high parity plus two stops |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Holding register free |
| cts | input | 1 | Far end ready; high allows a new frame |
| tx | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |

## Verification
A wrong slot counter or a wrong stretch lookup shows on the line within one slot as an edge that comes one or more clocks early or late. The bench compares every clock of each frame against a waveform built from the divisor, mask and layout. A slot sequencer that stops too early or too late shows as busy falling on the wrong clock at the end of the frame. A corrupted shift register shows as a wrong level within the data slots. A holding register that loses or repeats bytes shows in the back-to-back test as wrong data in the second frame, or as a third frame that should not be there.

// File: rtl/fut_pkg.sv
package fut_pkg;
    typedef enum logic [1:0] {
        FMT_ONE_STOP  = 2'd0,
        FMT_TWO_STOP  = 2'd1,
        FMT_MARK_STOP = 2'd2,
        FMT_SPARE     = 2'd3
    } fut_fmt_e;
endpackage

// File: rtl/fut_cfg_regs.sv
module fut_cfg_regs
    import fut_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int MASK_W  = 12,
    parameter int MIN_DIV = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              we_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [MASK_W-1:0] mask_i,
    input  fut_fmt_e          fmt_i,
    output logic [DIV_W-1:0]  div_o,
    output logic [MASK_W-1:0] mask_o,
    output fut_fmt_e          fmt_o
);
    localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [MASK_W-1:0] mask;
        fut_fmt_e          fmt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i && !busy_i) begin
            cfg_d.div  = (div_i < DIV_FLOOR) ? DIV_FLOOR : div_i;
            cfg_d.mask = mask_i;
            cfg_d.fmt  = fmt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{div: DIV_FLOOR, mask: '0, fmt: FMT_ONE_STOP};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign div_o  = cfg_q.div;
    assign mask_o = cfg_q.mask;
    assign fmt_o  = cfg_q.fmt;

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(div_o) && $stable(mask_o) && $stable(fmt_o)));

    // R4
    div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_o >= DIV_FLOOR);
endmodule

// File: rtl/fut_slot_timer.sv
module fut_slot_timer #(
    parameter int DIV_W  = 16,
    parameter int MASK_W = 12,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic              slot_end_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic             stretch;
    logic [DIV_W-1:0] last_cnt;

    always_comb begin
        stretch = 1'b0;
        for (int i = 0; i < MASK_W; i++) begin
            if (slot_i == SLOT_W'(i)) stretch = mask_i[i];
        end
        last_cnt   = stretch ? div_i : (div_i - 1'b1);
        slot_end_o = busy_i && (tmr_q.cnt == last_cnt);
        tmr_d      = tmr_q;
        if (!busy_i || slot_end_o) tmr_d.cnt = '0;
        else                       tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '{cnt: '0};
        else        tmr_q <= tmr_d;
    end

    // R4 R5
    slot_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= div_i);
endmodule

// File: rtl/fut_frame_ctrl.sv
module fut_frame_ctrl
    import fut_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fut_fmt_e          fmt_i,
    input  logic              cts_i,
    input  logic              slot_end_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    output logic              tx_o,
    output logic              busy_o,
    output logic [SLOT_W-1:0] slot_o
);
    localparam logic [SLOT_W-1:0] LAST_ONE  = SLOT_W'(DATA_W + 1);
    localparam logic [SLOT_W-1:0] LAST_TWO  = SLOT_W'(DATA_W + 2);
    localparam logic [SLOT_W-1:0] LAST_MARK = SLOT_W'(DATA_W + 3);
    localparam logic [SLOT_W-1:0] DATA_TOP  = SLOT_W'(DATA_W);

    typedef struct packed {
        logic              hold_full;
        logic [DATA_W-1:0] hold_data;
        logic [DATA_W-1:0] shift;
        logic [SLOT_W-1:0] slot;
        logic              busy;
        logic              tx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [SLOT_W-1:0] last_slot;
    logic [SLOT_W-1:0] next_slot;
    logic              accept;
    logic              frame_done;
    logic              can_start;

    always_comb begin
        unique case (fmt_i)
            FMT_TWO_STOP:  last_slot = LAST_TWO;
            FMT_MARK_STOP: last_slot = LAST_MARK;
            default:       last_slot = LAST_ONE;
        endcase
        next_slot  = ctl_q.slot + 1'b1;
        accept     = in_valid_i && !ctl_q.hold_full;
        frame_done = ctl_q.busy && slot_end_i && (ctl_q.slot == last_slot);
        can_start  = ctl_q.hold_full && cts_i && (!ctl_q.busy || frame_done);

        ctl_d = ctl_q;
        if (accept) begin
            ctl_d.hold_full = 1'b1;
            ctl_d.hold_data = in_data_i;
        end
        if (can_start) begin
            ctl_d.hold_full = 1'b0;
            ctl_d.shift     = ctl_q.hold_data;
            ctl_d.slot      = '0;
            ctl_d.busy      = 1'b1;
            ctl_d.tx        = 1'b0;
        end else if (frame_done) begin
            ctl_d.slot = '0;
            ctl_d.busy = 1'b0;
            ctl_d.tx   = 1'b1;
        end else if (ctl_q.busy && slot_end_i) begin
            ctl_d.slot = next_slot;
            if (next_slot <= DATA_TOP) begin
                ctl_d.tx    = ctl_q.shift[0];
                ctl_d.shift = ctl_q.shift >> 1;
            end else begin
                ctl_d.tx = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{hold_full: 1'b0, hold_data: '0, shift: '0,
                       slot: '0, busy: 1'b0, tx: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready_o = !ctl_q.hold_full;
    assign tx_o       = ctl_q.tx;
    assign busy_o     = ctl_q.busy;
    assign slot_o     = ctl_q.slot;

    // R12
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o);

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !tx_o);

    // R10
    start_needs_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cts_i));

    // R2
    byte_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> !in_ready_o);

    // R12
    slot_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (slot_o <= last_slot));
endmodule

// File: rtl/frac_uart_tx.sv
module frac_uart_tx
    import fut_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int MIN_DIV = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [11:0]      cfg_mask,
    input  logic [1:0]       cfg_fmt,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             cts,
    output logic             tx,
    output logic             busy
);
    localparam int DATA_W    = 8;
    localparam int MAX_SLOTS = DATA_W + 4;
    localparam int MASK_W    = MAX_SLOTS;
    localparam int SLOT_W    = $clog2(MAX_SLOTS);

    logic [DIV_W-1:0]  div_w;
    logic [MASK_W-1:0] mask_w;
    fut_fmt_e          fmt_w;
    logic [SLOT_W-1:0] slot_w;
    logic              slot_end_w;

    fut_cfg_regs #(.DIV_W(DIV_W), .MASK_W(MASK_W), .MIN_DIV(MIN_DIV)) u_cfg (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .we_i(cfg_we),
        .div_i(cfg_div), .mask_i(cfg_mask), .fmt_i(fut_fmt_e'(cfg_fmt)),
        .div_o(div_w), .mask_o(mask_w), .fmt_o(fmt_w)
    );

    fut_slot_timer #(.DIV_W(DIV_W), .MASK_W(MASK_W), .SLOT_W(SLOT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .slot_i(slot_w),
        .div_i(div_w), .mask_i(mask_w), .slot_end_o(slot_end_w)
    );

    fut_frame_ctrl #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .fmt_i(fmt_w), .cts_i(cts),
        .slot_end_i(slot_end_w), .in_data_i(in_data), .in_valid_i(in_valid),
        .in_ready_o(in_ready), .tx_o(tx), .busy_o(busy), .slot_o(slot_w)
    );
endmodule

// File: tb/tb_frac_uart_tx.sv
module tb_frac_uart_tx;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_div = 16'd14;
    logic [11:0] cfg_mask = '0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready, tx, busy;
    logic        cts = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    frac_uart_tx dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
        .cfg_mask(cfg_mask), .cfg_fmt(cfg_fmt), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .cts(cts), .tx(tx), .busy(busy)
    );

    // {fmt, div, mask, data}
    localparam logic [37:0] VEC [0:7] = '{
        {2'd0, 16'd14, 12'h000, 8'hA5},
        {2'd0, 16'd16, 12'h2A5, 8'h3C},
        {2'd1, 16'd15, 12'h401, 8'h81},
        {2'd2, 16'd14, 12'hFFF, 8'h00},
        {2'd0, 16'd14, 12'hC00, 8'hFF},
        {2'd0, 16'd5,  12'h000, 8'h96},
        {2'd2, 16'd17, 12'h555, 8'h6E},
        {2'd1, 16'd20, 12'h800, 8'h12}
    };
    localparam string VTAG [0:7] = '{"R3 R4", "R5", "R7", "R8 R5", "R9",
                                     "R4 clamp", "R8", "R7 R9"};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] f, input logic [15:0] d, input logic [11:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_fmt = f; cfg_div = d; cfg_mask = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic push(input logic [7:0] b);
        in_valid = 1'b1; in_data = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // first sample is the current falling edge, which must show the start slot
    task automatic check_frame(input logic [1:0] f, input logic [15:0] d,
                               input logic [11:0] m, input logic [7:0] b,
                               input bit b2b, input string req);
        int cd, ns, bad;
        cd  = (d < 16'd14) ? 14 : int'(d);
        ns  = (f == 2'd1) ? 11 : (f == 2'd2) ? 12 : 10;
        bad = 0;
        for (int s = 0; s < ns; s++) begin
            logic ev;
            ev = (s == 0) ? 1'b0 : (s <= 8) ? b[s-1] : 1'b1;
            for (int c = 0; c < cd + int'(m[s]); c++) begin
                if (tx !== ev || busy !== 1'b1) bad++;
                @(negedge clk);
            end
        end
        chk(bad == 0, {req, " frame waveform mismatching clocks"}, bad, 0);
        if (b2b) chk(busy === 1'b1 && tx === 1'b0, "R13 next start follows", {busy, tx}, 2'b10);
        else     chk(busy === 1'b0 && tx === 1'b1, {req, " R12 end of frame"}, {busy, tx}, 2'b01);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(tx === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R1 reset state",
            {tx, busy, in_ready}, 3'b101);

        for (int i = 0; i < 8; i++) begin
            set_cfg(VEC[i][37:36], VEC[i][35:20], VEC[i][19:8]);
            push(VEC[i][7:0]);
            @(negedge clk);
            check_frame(VEC[i][37:36], VEC[i][35:20], VEC[i][19:8], VEC[i][7:0], 1'b0, VTAG[i]);
        end

        // R10: no start while cts low, frame starts once raised
        set_cfg(2'd0, 16'd14, 12'h000);
        cts = 1'b0;
        push(8'h4B);
        repeat (40) @(negedge clk);
        chk(tx === 1'b1 && busy === 1'b0 && in_ready === 1'b0, "R10 held by cts",
            {tx, busy, in_ready}, 3'b100);
        cts = 1'b1;
        @(negedge clk);
        check_frame(2'd0, 16'd14, 12'h000, 8'h4B, 1'b0, "R10 release");

        // R10: dropping cts mid-frame does not cut the frame
        push(8'h77);
        @(negedge clk);
        cts = 1'b0;
        repeat (10*14 - 1) @(negedge clk);
        chk(busy === 1'b1, "R10 frame runs to end", busy, 1);
        @(negedge clk);
        chk(busy === 1'b0 && tx === 1'b1, "R10 frame ends on time", {busy, tx}, 2'b01);
        cts = 1'b1;

        // R11: configuration write during a frame is discarded
        push(8'hD2);
        @(negedge clk);
        cfg_we = 1'b1; cfg_div = 16'd40; cfg_fmt = 2'd2; cfg_mask = 12'hFFF;
        @(negedge clk);
        cfg_we = 1'b0;
        while (busy) @(negedge clk);
        push(8'h2D);
        @(negedge clk);
        check_frame(2'd0, 16'd14, 12'h000, 8'h2D, 1'b0, "R11 write while busy ignored");

        // R2 R6 R13: back-to-back frames with one held byte
        set_cfg(2'd0, 16'd14, 12'h013);
        push(8'h5A);
        @(negedge clk);
        fork
            check_frame(2'd0, 16'd14, 12'h013, 8'h5A, 1'b1, "R13 first");
            begin
                push(8'hC3);
                chk(in_ready === 1'b0, "R2 ready low while held", in_ready, 0);
                in_valid = 1'b1; in_data = 8'hEE;
                repeat (5) @(negedge clk);
                in_valid = 1'b0;
            end
        join
        check_frame(2'd0, 16'd14, 12'h013, 8'hC3, 1'b0, "R6 R2 second");
        repeat (20) @(negedge clk);
        chk(busy === 1'b0 && tx === 1'b1 && in_ready === 1'b1, "R2 refused byte not sent",
            {busy, tx, in_ready}, 3'b011);

        finish_run();
    end
endmodule